// File: doc/BRIEF.md
# Received Pause Transmit Throttle

This block sits in the transmit side of an Ethernet MAC. It stops new transmission after the link partner sends a pause request. A receive-side parser hands it a strobe and a 16-bit pause quanta. When flow control is on, the block waits for any frame that is already being sent to finish. It then raises a hold toward the transmitter for quanta × 512 bit times, and it shows a remote-pause status flag for as long as the countdown runs.

A newer quanta replaces the remaining time. A quanta of zero ends the pause at once. A prescaler turns bit-time ticks into 512-bit-time units. It counts 512 ticks per unit when the tick comes once per bit, or 64 ticks per unit when the tick comes once per byte. Separately from flow control, a forward enable decides whether each received pause frame is passed on to the client.

Top module: `rx_pause_throttle`

## Requirements
- R1: After reset, `tx_hold`, `pause_flag` and `fwd_pulse` are all 0.
- R2: A nonzero quanta Q keeps `pause_flag` high for exactly Q×T `bit_tick` pulses. T is 512 when `BYTE_TICK`=0 and 64 when `BYTE_TICK`=1. A tick counts when it is high at a rising clock edge while `pause_flag` is high.
- R3: A quanta accepted while `frame_busy` is high raises `tx_hold` in the next cycle but leaves `pause_flag` low. `pause_flag` rises in the cycle after `frame_busy` is first seen low, and only then does the countdown start.
- R4: `pause_flag` is high only while the countdown runs, and `tx_hold` is high whenever `pause_flag` is high.
- R5: When the countdown ends, both `tx_hold` and `pause_flag` go low in the next cycle.
- R6: A nonzero quanta accepted during a countdown restarts it. The hold then lasts exactly new-Q×T further ticks.
- R7: An accepted quanta of 0x0000 clears `tx_hold` and `pause_flag` in the next cycle. When the block is idle it has no effect.
- R8: While `fc_en` is 0, quanta strobes never raise `tx_hold` or `pause_flag`.
- R9: Clearing `fc_en` during a pause drops `tx_hold` and `pause_flag` in the next cycle.
- R10: `fwd_pulse` is high for one cycle after each strobe with `fwd_en`=1 and is low otherwise, whatever the value of `fc_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fc_en | input | 1 | Flow-control enable |
| fwd_en | input | 1 | Forward received pause frames to the client |
| quanta_vld | input | 1 | Strobe: a pause quanta was decoded |
| quanta | input | QW | Received pause quanta |
| frame_busy | input | 1 | Transmitter is sending a frame |
| bit_tick | input | 1 | One pulse per bit time (per byte when BYTE_TICK=1) |
| tx_hold | output | 1 | Do not start a new frame |
| pause_flag | output | 1 | Remote pause in effect |
| fwd_pulse | output | 1 | Pass the received pause frame to the client |

## Verification
Two cases are hard to reach from the ports. The first is a quanta that arrives in the middle of a frame. The bench holds `frame_busy` high across the strobe and for many cycles after it, then checks that `tx_hold` is high, `pause_flag` stays low, and the countdown starts only once the frame ends. The second is a reload landing part-way into a countdown with ticks arriving irregularly. For this the bench drives `bit_tick` from an LFSR and counts the ticks that fall while the flag is high, so the expected total is Q×T whatever the tick phase. Quanta values 1 to 5 are swept under both regular and irregular ticks.

// File: rtl/rx_pause_throttle.sv
module rx_pause_throttle #(
  parameter bit BYTE_TICK = 1'b0,
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fc_en,
  input  logic          fwd_en,
  input  logic          quanta_vld,
  input  logic [QW-1:0] quanta,
  input  logic          frame_busy,
  input  logic          bit_tick,
  output logic          tx_hold,
  output logic          pause_flag,
  output logic          fwd_pulse
);
  localparam int TPQ = BYTE_TICK ? 64 : 512;
  localparam int PW = $clog2(TPQ);

  logic          active, pending, fwd_q;
  logic [QW-1:0] rem, held;
  logic [PW-1:0] pre;

  wire take = quanta_vld & fc_en;
  wire zero = (quanta == '0);
  wire unit_done = bit_tick & (pre == PW'(TPQ - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      pending <= 1'b0;
      rem     <= '0;
      held    <= '0;
      pre     <= '0;
    end else if (!fc_en || (take && zero)) begin
      active  <= 1'b0;
      pending <= 1'b0;
    end else if (take && (active || !frame_busy)) begin
      active  <= 1'b1;
      pending <= 1'b0;
      rem     <= quanta;
      pre     <= '0;
    end else if (take) begin
      pending <= 1'b1;
      held    <= quanta;
    end else if (pending && !frame_busy) begin
      active  <= 1'b1;
      pending <= 1'b0;
      rem     <= held;
      pre     <= '0;
    end else if (active && bit_tick) begin
      pre <= unit_done ? '0 : pre + PW'(1);
      if (unit_done) begin
        if (rem == QW'(1)) active <= 1'b0;
        else rem <= rem - QW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fwd_q <= 1'b0;
    else        fwd_q <= quanta_vld & fwd_en;
  end

  assign tx_hold    = active | pending;
  assign pause_flag = active;
  assign fwd_pulse  = fwd_q;
endmodule

// File: rtl/rx_pause_throttle_chk.sv
module rx_pause_throttle_chk (
  input logic clk,
  input logic rst_n,
  input logic fc_en,
  input logic fwd_en,
  input logic quanta_vld,
  input logic zero_q,
  input logic frame_busy,
  input logic tx_hold,
  input logic pause_flag,
  input logic fwd_pulse
);
  assert_flag_has_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pause_flag |-> tx_hold);
  assert_busy_defers_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pause_flag && frame_busy) |=> !pause_flag);
  assert_zero_cancels_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (quanta_vld && fc_en && zero_q) |=> (!tx_hold && !pause_flag));
  assert_disable_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_en |=> (!tx_hold && !pause_flag));
  assert_fwd_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (quanta_vld && fwd_en) |=> fwd_pulse);
  assert_fwd_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(quanta_vld && fwd_en) |=> !fwd_pulse);
endmodule

bind rx_pause_throttle rx_pause_throttle_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fc_en(fc_en), .fwd_en(fwd_en),
  .quanta_vld(quanta_vld), .zero_q(quanta == '0), .frame_busy(frame_busy),
  .tx_hold(tx_hold), .pause_flag(pause_flag), .fwd_pulse(fwd_pulse)
);

// File: tb/rx_pause_throttle_bench.sv
module rx_pause_throttle_bench;
  localparam int CLK_PERIOD = 10;
  localparam int T = 64;

  logic clk = 0, rst_n = 0, fc_en = 0, fwd_en = 0, quanta_vld = 0, frame_busy = 0, bit_tick = 0;
  logic [15:0] quanta = '0;
  logic tx_hold, pause_flag, fwd_pulse;
  int checks = 0, errors = 0;
  bit tick_rand = 0;
  logic [7:0] lfsr = 8'h5a;

  rx_pause_throttle #(.BYTE_TICK(1'b1), .QW(16)) u_rx_pause_throttle (
    .clk(clk), .rst_n(rst_n), .fc_en(fc_en), .fwd_en(fwd_en),
    .quanta_vld(quanta_vld), .quanta(quanta), .frame_busy(frame_busy),
    .bit_tick(bit_tick), .tx_hold(tx_hold), .pause_flag(pause_flag),
    .fwd_pulse(fwd_pulse));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    bit_tick = tick_rand ? lfsr[0] : 1'b1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [15:0] q);
    quanta = q; quanta_vld = 1;
    @(negedge clk);
    quanta_vld = 0;
  endtask

  task automatic measure(output int cnt, output int nohold);
    int guard = 0;
    cnt = 0; nohold = 0;
    while (pause_flag && guard < 100000) begin
      if (bit_tick) cnt++;
      if (!tx_hold) nohold++;
      guard++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    int cnt, nh;
    repeat (3) @(negedge clk);
    check(!tx_hold && !pause_flag && !fwd_pulse, "R1", {tx_hold, pause_flag, fwd_pulse}, 0);
    rst_n = 1; fc_en = 1;
    @(negedge clk);

    for (int m = 0; m < 2; m++) begin
      tick_rand = m[0];
      for (int q = 1; q <= 5; q++) begin
        strobe(16'(q));
        measure(cnt, nh);
        check(cnt == q * T, "R2", cnt, q * T);
        check(nh == 0, "R4", nh, 0);
        check(!tx_hold && !pause_flag, "R5", {tx_hold, pause_flag}, 0);
        @(negedge clk);
      end
    end

    tick_rand = 0;
    strobe(16'd200);
    measure(cnt, nh);
    check(cnt == 200 * T, "R2", cnt, 200 * T);

    tick_rand = 1;
    frame_busy = 1;
    strobe(16'd2);
    check(tx_hold && !pause_flag, "R3", {tx_hold, pause_flag}, 2);
    repeat (10) @(negedge clk);
    check(tx_hold && !pause_flag, "R3", {tx_hold, pause_flag}, 2);
    frame_busy = 0;
    @(negedge clk);
    check(pause_flag == 1, "R3", pause_flag, 1);
    measure(cnt, nh);
    check(cnt == 2 * T, "R3", cnt, 2 * T);

    strobe(16'd3);
    repeat (50) @(negedge clk);
    check(pause_flag == 1, "R6", pause_flag, 1);
    strobe(16'd1);
    measure(cnt, nh);
    check(cnt == T, "R6", cnt, T);

    strobe(16'd5);
    repeat (20) @(negedge clk);
    strobe(16'd0);
    check(!tx_hold && !pause_flag, "R7", {tx_hold, pause_flag}, 0);
    strobe(16'd0);
    repeat (3) @(negedge clk);
    check(!tx_hold && !pause_flag, "R7", {tx_hold, pause_flag}, 0);

    fc_en = 0;
    strobe(16'd4);
    for (int i = 0; i < 20; i++) begin
      if (tx_hold || pause_flag) begin
        check(0, "R8", {tx_hold, pause_flag}, 0);
        break;
      end
      @(negedge clk);
    end
    check(!tx_hold && !pause_flag, "R8", {tx_hold, pause_flag}, 0);

    fc_en = 1;
    strobe(16'd4);
    repeat (5) @(negedge clk);
    fc_en = 0;
    @(negedge clk);
    check(!tx_hold && !pause_flag, "R9", {tx_hold, pause_flag}, 0);

    for (int c = 0; c < 4; c++) begin
      fwd_en = c[0]; fc_en = c[1];
      strobe(16'd0);
      check(fwd_pulse == c[0], "R10", fwd_pulse, c[0]);
      @(negedge clk);
      check(fwd_pulse == 0, "R10", fwd_pulse, 0);
    end

    finish_run();
  end
endmodule